// File: doc/BRIEF.md
# Ethernet Nibble Transmit Port

This block turns a byte stream from a MAC into the 4-bit transmit side of a Media Independent Interface. The PHY supplies the clock, and every output of the block is a register on that clock. When a frame is waiting, the block first sends a run of preamble nibbles and a start-of-frame delimiter. It then sends each payload byte as two nibbles, low half first, and raises the line enable for the whole frame. When the last nibble has gone out, the line returns to idle and stays there for at least a full interframe gap.

Errors are reported to the PHY with the error line raised while the enable line is still high. This happens when the MAC side requests an abort, or when the next byte is missing at the moment it is needed. The error nibble lasts one clock, and the frame ends on the clock after it. Any bytes of the broken frame that the MAC has not yet delivered are read and dropped, up to and including the byte flagged as last. The next frame then starts clean.

Top module: `nib_tx_port`

## Requirements
- R1: While reset is held and on the first clock after reset, `phy_en`, `phy_err` and `s_ready` are all 0.
- R2: A frame begins with `phy_en` rising together with the first of PRE_COUNT (default 15) nibbles of value 0x5, followed by one nibble of value 0xD. The first payload nibble comes on the next clock.
- R3: Each payload byte is sent as two consecutive nibbles, bits [3:0] first and then bits [7:4], with byte bit 0 on `phy_nib[0]`. Bytes appear in the order in which they were accepted.
- R4: In a frame without error, `phy_en` stays high for exactly 16 + 2·N clocks for N payload bytes, `phy_err` stays 0 throughout, and `phy_en` falls on the clock after the last nibble.
- R5: `s_ready` is high while the line is enabled only in the delimiter clock and in the clocks that carry the high nibble of a byte not flagged last. A byte moves when `s_valid` and `s_ready` are both high at a rising edge.
- R6: If `abort_req` is high at an edge while a frame is on the line, the next clock carries `phy_en`=1 with `phy_err`=1, and the clock after that has both at 0.
- R7: After an error frame, the block reads and drops the remaining bytes of that frame through the one flagged last, without driving the line. The next frame is sent intact.
- R8: If `s_valid` is low in a clock where `s_ready` is high during a frame (underrun), the next clock carries the error code as in R6, and the frame ends on the clock after it.
- R9: `phy_err` is never 1 while `phy_en` is 0.
- R10: Between two frames `phy_en` is low for at least IFG_CLKS (default 24) clocks. It is low for exactly that many clocks when the next frame's first byte is already offered when the gap ends.
- R11: `abort_req` has no effect while no frame is on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit clock supplied by the PHY |
| rst_n | input | 1 | Active-low reset, synchronous to tx_clk |
| s_byte | input | BYTE_W | Payload byte offered by the MAC |
| s_valid | input | 1 | s_byte holds a byte |
| s_last | input | 1 | s_byte is the final byte of its frame |
| s_ready | output | 1 | Block takes s_byte at this edge if s_valid |
| abort_req | input | 1 | Request to abandon the frame on the line |
| phy_nib | output | BYTE_W/2 | Transmit nibble toward the PHY |
| phy_en | output | 1 | Line enable, high for the whole frame |
| phy_err | output | 1 | Error propagation, high only together with phy_en |

## Verification
The bench builds the block with its default parameters: a 15-nibble preamble, 8-bit bytes and a 24-clock gap. With these values, the gap length and the frame length can be checked as exact clock counts. Frame lengths of 1 to 24 bytes put the error injection points across the preamble, the delimiter, both nibble phases and the final nibble. The gap is short enough that back-to-back frames, draining after an error, and stray aborts while the line is idle all occur many times within one run.

// File: rtl/nib_tx_pkg.sv
package nib_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_PRE,
        TX_SFD,
        TX_LO,
        TX_HI,
        TX_ERR,
        TX_DRAIN
    } tx_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRE,
        SEL_SFD,
        SEL_IN_LO,
        SEL_HOLD_HI
    } nib_sel_e;

endpackage

// File: rtl/nib_tx_gap_timer.sv
module nib_tx_gap_timer #(
    parameter int IFG_CLKS = 24
) (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic line_on_d,
    output logic gap_open
);
    localparam int CW = $clog2(IFG_CLKS + 1);
    localparam logic [CW-1:0] FULL = CW'(IFG_CLKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (line_on_d) begin
            cnt_d = '0;
        end else if (cnt_q == FULL) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge tx_clk) begin
        if (!rst_n) begin
            cnt_q <= FULL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign gap_open = (cnt_q == FULL);

endmodule

// File: rtl/nib_tx_nib_sel.sv
module nib_tx_nib_sel
    import nib_tx_pkg::*;
#(
    parameter int               NIB_W   = 4,
    parameter logic [NIB_W-1:0] PRE_PAT = 4'h5,
    parameter logic [NIB_W-1:0] SFD_PAT = 4'hD
) (
    input  nib_sel_e         sel,
    input  logic [NIB_W-1:0] in_lo,
    input  logic [NIB_W-1:0] hold_hi,
    output logic [NIB_W-1:0] nib
);
    always_comb begin
        unique case (sel)
            SEL_PRE:     nib = PRE_PAT;
            SEL_SFD:     nib = SFD_PAT;
            SEL_IN_LO:   nib = in_lo;
            SEL_HOLD_HI: nib = hold_hi;
            default:     nib = '0;
        endcase
    end

endmodule

// File: rtl/nib_tx_port.sv
module nib_tx_port
    import nib_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int PRE_COUNT = 15,
    parameter int IFG_CLKS  = 24
) (
    input  logic              tx_clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] s_byte,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              abort_req,
    output logic [BYTE_W/2-1:0] phy_nib,
    output logic              phy_en,
    output logic              phy_err
);
    localparam int NIB_W = BYTE_W / 2;
    localparam int PRE_W = $clog2(PRE_COUNT + 1);
    localparam logic [PRE_W-1:0] PRE_END = PRE_W'(PRE_COUNT);
    localparam logic [NIB_W-1:0] PRE_PAT = NIB_W'(4'h5);
    localparam logic [NIB_W-1:0] SFD_PAT = NIB_W'(4'hD);

    typedef struct packed {
        tx_state_e        st;
        logic [PRE_W-1:0] pre;
        logic [NIB_W-1:0] hold;
        logic             hold_last;
        logic             fin;
        logic             en;
        logic             err;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    nib_sel_e         sel_d;
    logic [NIB_W-1:0] nib_d, nib_q;
    logic             gap_open;
    logic             ready_d;

    // Next-state computation for the whole port
    always_comb begin
        ctl_d   = ctl_q;
        ctl_d.en  = 1'b0;
        ctl_d.err = 1'b0;
        sel_d   = SEL_NONE;
        ready_d = 1'b0;
        unique case (ctl_q.st)
            TX_IDLE: begin
                if (s_valid && gap_open) begin
                    ctl_d.st        = TX_PRE;
                    ctl_d.pre       = PRE_W'(1);
                    ctl_d.fin       = 1'b0;
                    ctl_d.hold_last = 1'b0;
                    ctl_d.en        = 1'b1;
                    sel_d           = SEL_PRE;
                end
            end
            TX_PRE: begin
                ctl_d.en = 1'b1;
                if (abort_req) begin
                    ctl_d.st  = TX_ERR;
                    ctl_d.err = 1'b1;
                end else if (ctl_q.pre == PRE_END) begin
                    ctl_d.st = TX_SFD;
                    sel_d    = SEL_SFD;
                end else begin
                    ctl_d.pre = ctl_q.pre + 1'b1;
                    sel_d     = SEL_PRE;
                end
            end
            TX_SFD, TX_HI: begin
                ctl_d.en = 1'b1;
                if (abort_req) begin
                    ctl_d.st  = TX_ERR;
                    ctl_d.err = 1'b1;
                end else if (ctl_q.st == TX_HI && ctl_q.hold_last) begin
                    ctl_d.st = TX_IDLE;
                    ctl_d.en = 1'b0;
                end else begin
                    ready_d = 1'b1;
                    if (!s_valid) begin
                        ctl_d.st  = TX_ERR;
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.st        = TX_LO;
                        ctl_d.hold      = s_byte[BYTE_W-1:NIB_W];
                        ctl_d.hold_last = s_last;
                        ctl_d.fin       = s_last;
                        sel_d           = SEL_IN_LO;
                    end
                end
            end
            TX_LO: begin
                ctl_d.en = 1'b1;
                if (abort_req) begin
                    ctl_d.st  = TX_ERR;
                    ctl_d.err = 1'b1;
                end else begin
                    ctl_d.st = TX_HI;
                    sel_d    = SEL_HOLD_HI;
                end
            end
            TX_ERR: begin
                ctl_d.st = ctl_q.fin ? TX_IDLE : TX_DRAIN;
            end
            TX_DRAIN: begin
                ready_d = 1'b1;
                if (s_valid && s_last) begin
                    ctl_d.st = TX_IDLE;
                end
            end
            default: begin
                ctl_d.st = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge tx_clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            nib_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            nib_q <= nib_d;
        end
    end

    nib_tx_nib_sel #(
        .NIB_W   (NIB_W),
        .PRE_PAT (PRE_PAT),
        .SFD_PAT (SFD_PAT)
    ) i_sel (
        .sel     (sel_d),
        .in_lo   (s_byte[NIB_W-1:0]),
        .hold_hi (ctl_q.hold),
        .nib     (nib_d)
    );

    nib_tx_gap_timer #(
        .IFG_CLKS (IFG_CLKS)
    ) i_gap (
        .tx_clk    (tx_clk),
        .rst_n     (rst_n),
        .line_on_d (ctl_d.en),
        .gap_open  (gap_open)
    );

    assign s_ready = ready_d;
    assign phy_nib = nib_q;
    assign phy_en  = ctl_q.en;
    assign phy_err = ctl_q.err;

    // R9
    no_reserved_code_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        phy_err |-> phy_en);

    // R6
    err_one_clock_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        phy_err |=> (!phy_err && !phy_en));

    // R2
    pre_first_nib_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        $rose(phy_en) |-> (phy_nib == PRE_PAT));

    // R10
    gap_kept_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        $rose(phy_en) |-> $past(gap_open));

    // R5
    ready_no_err_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
        s_ready |-> !phy_err);

endmodule

// File: tb/test_nib_tx_port.sv
module test_nib_tx_port;
    localparam int CLK_PERIOD = 10;
    localparam int NF     = 40;
    localparam int MAXLEN = 24;
    localparam int IFG    = 24;
    localparam int LIMIT  = 20000;

    logic       tx_clk = 1'b0;
    logic       rst_n  = 1'b0;
    logic [7:0] s_byte = '0;
    logic       s_valid = 1'b0;
    logic       s_last  = 1'b0;
    logic       s_ready;
    logic       abort_req = 1'b0;
    logic [3:0] phy_nib;
    logic       phy_en;
    logic       phy_err;

    always #(CLK_PERIOD/2) tx_clk = ~tx_clk;

    nib_tx_port i_nib_tx_port (
        .tx_clk    (tx_clk),
        .rst_n     (rst_n),
        .s_byte    (s_byte),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .abort_req (abort_req),
        .phy_nib   (phy_nib),
        .phy_en    (phy_en),
        .phy_err   (phy_err)
    );

    logic [7:0] fbytes [NF][MAXLEN];
    int  flen [NF];
    int  fdel [NF];
    int  fab  [NF];
    int  fst  [NF];
    bit  tight[NF];

    int checks = 0;
    int fails  = 0;

    logic [3:0] cap_nib [128];
    bit         cap_err [128];
    int ncap, nerr, hc, lowrun, mi, fi, bi, waitc, cyc, bad_r5, bad_r9;
    bit prev_en, prev_bad;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_nib(int f, int i);
        logic [7:0] b;
        if (i < 15) return 4'h5;
        if (i == 15) return 4'hD;
        b = fbytes[f][(i-16)/2];
        return ((i-16) % 2 == 1) ? b[7:4] : b[3:0];
    endfunction

    task automatic check_frame(int f);
        int  nexp;
        int  upto;
        int  bad_pre = -1;
        int  bad_dat = -1;
        bit  is_err = (fab[f] != 0) || (fst[f] != 0);
        nexp = 16 + 2*flen[f];
        upto = is_err ? ncap - 1 : ncap;
        for (int i = 0; i < upto && i < nexp; i++) begin
            if (cap_nib[i] != exp_nib(f, i)) begin
                if (i < 16 && bad_pre < 0) bad_pre = i;
                if (i >= 16 && bad_dat < 0) bad_dat = i;
            end
        end
        if (!is_err) begin
            check(ncap == nexp, "R4", "frame length", ncap, nexp);
            check(nerr == 0, "R4", "error clocks in clean frame", nerr, 0);
            check(bad_pre < 0, "R2", "preamble/delimiter mismatch at nibble", bad_pre, -1);
            check(bad_dat < 0, "R3", "payload mismatch at nibble", bad_dat, -1);
            if (prev_bad)
                check(bad_pre < 0 && bad_dat < 0 && ncap == nexp, "R7",
                      "frame after error not intact", ncap, nexp);
        end else if (fab[f] != 0) begin
            check(ncap == fab[f] + 1, "R6", "aborted frame length", ncap, fab[f] + 1);
            check(nerr == 1 && cap_err[ncap-1], "R6", "error clocks at end", nerr, 1);
            check(bad_pre < 0 && bad_dat < 0, "R6", "prefix before abort", bad_pre + bad_dat, -2);
        end else begin
            check(ncap == 17 + 2*fst[f], "R8", "underrun frame length", ncap, 17 + 2*fst[f]);
            check(nerr == 1 && cap_err[ncap-1], "R8", "error clocks at end", nerr, 1);
            check(bad_pre < 0 && bad_dat < 0, "R8", "prefix before underrun", bad_pre + bad_dat, -2);
        end
        prev_bad = is_err;
    endtask

    task automatic run_cycle();
        @(negedge tx_clk);
        cyc++;
        // monitor the outputs registered at the last edge
        if (phy_en) begin
            if (!prev_en) begin
                if (mi > 0) begin
                    check(lowrun >= IFG, "R10", "gap too short", lowrun, IFG);
                    if (tight[mi])
                        check(lowrun == IFG, "R10", "gap not minimal", lowrun, IFG);
                end
                hc = 0; ncap = 0; nerr = 0;
            end
            if (ncap < 128) begin
                cap_nib[ncap] = phy_nib;
                cap_err[ncap] = phy_err;
                ncap++;
            end
            if (phy_err) nerr++;
            hc++;
        end else begin
            if (prev_en) begin
                check_frame(mi);
                mi++;
                lowrun = 0;
            end
            lowrun++;
            if (phy_err) bad_r9++;
        end
        prev_en = phy_en;
        // drive inputs
        abort_req = 1'b0;
        if (phy_en) begin
            if (mi < NF && fab[mi] != 0 && hc == fab[mi]) abort_req = 1'b1;
        end else if (($urandom % 8) == 0) begin
            abort_req = 1'b1; // R11: stray abort while the line is idle
        end
        if (fi >= NF || waitc > 0) begin
            s_valid = 1'b0;
            s_byte  = 8'($urandom);
            s_last  = 1'b0;
        end else begin
            s_valid = 1'b1;
            s_byte  = fbytes[fi][bi];
            s_last  = (bi == flen[fi] - 1);
        end
        #1;
        if (s_ready && phy_en && !(hc >= 16 && hc % 2 == 0)) bad_r5++;
        if (s_valid && s_ready) begin
            if (s_last) begin
                fi++;
                bi = 0;
                waitc = (fi < NF) ? fdel[fi] : 0;
            end else begin
                bi++;
                if (fst[fi] == bi) waitc = 4;
            end
        end else if (!s_valid && waitc > 0) begin
            waitc--;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int f = 0; f < NF; f++) begin
            flen[f] = 1 + ($urandom % MAXLEN);
            fdel[f] = $urandom % 4;
            fab[f]  = 0;
            fst[f]  = 0;
            for (int b = 0; b < MAXLEN; b++) fbytes[f][b] = 8'($urandom);
            if (f >= 7) begin
                case ($urandom % 6)
                    0: fab[f] = 1 + ($urandom % (16 + 2*flen[f]));
                    1: if (flen[f] >= 2) fst[f] = 1 + ($urandom % (flen[f] - 1));
                    default: ;
                endcase
            end
        end
        // directed corner cases
        flen[0] = 1; fdel[0] = 0;
        flen[1] = 3; fdel[1] = 0;
        flen[2] = 4; fab[2] = 1;
        flen[3] = 4; fab[3] = 16;
        flen[4] = 2; fab[4] = 20;
        flen[5] = 5; fst[5] = 1;
        flen[6] = 2; fdel[6] = 0;
        fbytes[0][0] = 8'hA5;
        fbytes[1][0] = 8'h0F; fbytes[1][1] = 8'hF0; fbytes[1][2] = 8'h81;
        for (int f = 0; f < NF; f++)
            tight[f] = (f > 0) && fdel[f] == 0 && fab[f-1] == 0 && fst[f-1] == 0;

        ncap = 0; nerr = 0; hc = 0; lowrun = 1000; mi = 0; fi = 0; bi = 0;
        waitc = 0; cyc = 0; bad_r5 = 0; bad_r9 = 0; prev_en = 0; prev_bad = 0;

        repeat (5) @(negedge tx_clk);
        check(!phy_en && !phy_err && !s_ready, "R1", "outputs during reset",
              {phy_en, phy_err, s_ready}, 0);
        rst_n = 1'b1;
        @(negedge tx_clk);
        check(!phy_en && !phy_err && !s_ready, "R1", "outputs after reset",
              {phy_en, phy_err, s_ready}, 0);
        // R11: abort with nothing on the line
        abort_req = 1'b1;
        @(negedge tx_clk);
        abort_req = 1'b0;
        check(!phy_en && !phy_err && !s_ready, "R11", "idle abort moved the line",
              {phy_en, phy_err, s_ready}, 0);

        waitc = fdel[0];
        while (mi < NF && cyc < LIMIT) run_cycle();

        check(cyc < LIMIT, "R4", "watchdog expired, frames seen", mi, NF);
        check(bad_r5 == 0, "R5", "ready outside allowed clocks", bad_r5, 0);
        check(bad_r9 == 0, "R9", "error without enable", bad_r9, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule